// File: doc/BRIEF.md
# Multi-lane sync request generator

This block turns the code group synchronization state of every receive lane into the one synchronization feedback signal that goes back to the transmitter. Each lane reports a 2-bit state. The code `2'b00` means that the lane is still looking for comma characters. The block reduces these per-lane flags to one internal sync request, using a rule chosen by a 3-bit selector. It registers the result and drives the output pin in either sense.

Straight after reset, the request does not come from the lanes. It follows a configured initial level for a fixed number of clock edges (`HOLD_CYCLES`). After that window the request tracks only the selected lane condition, with one register stage. The selector, the polarity bit and the initial level are quasi-static configuration inputs.

Top module: `sync_req_gen`

## Requirements
- R1: While `rst_ni` is low, and for the first `HOLD_CYCLES` rising edges after it goes high, the internal request equals `init_lvl_i`.
- R2: When `pol_i` is 0 the pin `sync_o` is the inverse of the internal request (active low). When `pol_i` is 1 the pin equals the request.
- R3: With `sel_i` = 3'b000 the request is 1 when at least one lane reports state 2'b00.
- R4: With `sel_i` = 3'b001 the request is 1 only when every lane reports state 2'b00.
- R5: With `sel_i` = 3'b010 the request is 1 exactly when lane 0 (bits [1:0]) reports 2'b00. With 3'b011 it is 1 exactly when lane 1 (bits [3:2]) reports 2'b00.
- R6: The codes 3'b100 to 3'b111 of `sel_i` behave exactly like 3'b000.
- R7: Once the hold window has ended, changes on `init_lvl_i` have no effect on `sync_o`.
- R8: Outside the hold window the request is registered. `sync_o` reflects the lane states and selector sampled at the previous rising edge.
- R9: Lane state codes 2'b01, 2'b10 and 2'b11 all count as "not in init".

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lane_state_i | input | 2*N_LANES | Per-lane synchronization state, lane n at bits [2n+1:2n] |
| sel_i | input | 3 | Lane aggregation rule |
| pol_i | input | 1 | Output sense: 0 active low, 1 active high |
| init_lvl_i | input | 1 | Request level held through and just after reset |
| sync_o | output | 1 | Synchronization request pin |

## Verification
The assertions take `pol_i` to be static whenever the output mapping is checked. They also take the lane count to be at least two, so that lane 1 exists. The stimulus changes lane states, selector and polarity only on falling edges, and it samples one full cycle later. Polarity is changed only between vectors, never during a comparison. A sweep covers all 256 state patterns of four lanes, every selector code and both polarities. Separate reset passes cover both initial levels and a toggle of `init_lvl_i` after release.

// File: rtl/sreq_pkg.sv
package sreq_pkg;
  localparam logic [1:0] CGS_INIT = 2'b00;

  typedef enum logic [2:0] {
    SEL_ANY   = 3'b000,
    SEL_ALL   = 3'b001,
    SEL_LANE0 = 3'b010,
    SEL_LANE1 = 3'b011
  } sel_mode_e;
endpackage

// File: rtl/sreq_lane_flags.sv
module sreq_lane_flags #(
  parameter int N_LANES = 4
) (
  input  logic [2*N_LANES-1:0] lane_state_i,
  output logic [N_LANES-1:0]   in_init_o
);
  import sreq_pkg::*;

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    assign in_init_o[g] = (lane_state_i[2*g +: 2] == CGS_INIT);
  end
endmodule

// File: rtl/sreq_select.sv
module sreq_select #(
  parameter int N_LANES = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LANES-1:0] in_init_i,
  input  logic [2:0]         sel_i,
  output logic               req_o
);
  import sreq_pkg::*;

  always_comb begin
    unique case (sel_i)
      SEL_ALL:   req_o = &in_init_i;
      SEL_LANE0: req_o = in_init_i[0];
      SEL_LANE1: req_o = in_init_i[1];
      default:   req_o = |in_init_i;  // any-lane, also for spare codes
    endcase
  end

  p_all_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 3'b001 && req_o) |-> ($countones(in_init_i) == N_LANES));
  p_any_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i[2] || sel_i == 3'b000) |-> (req_o == (in_init_i != '0)));
  p_lane_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == 3'b011 && in_init_i[1]) |-> req_o);
endmodule

// File: rtl/sreq_hold.sv
module sreq_hold #(
  parameter int HOLD_CYCLES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic hold_o
);
  localparam int CW = $clog2(HOLD_CYCLES + 1);
  localparam logic [CW-1:0] CNT_INIT = CW'(HOLD_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= CNT_INIT;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign hold_o = (cnt_q != '0);

  p_hold_after_rst_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rst_ni) |-> hold_o);
  p_release_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hold_o |=> !hold_o);
endmodule

// File: rtl/sync_req_gen.sv
module sync_req_gen #(
  parameter int N_LANES     = 4,
  parameter int HOLD_CYCLES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [2*N_LANES-1:0] lane_state_i,
  input  logic [2:0]           sel_i,
  input  logic                 pol_i,
  input  logic                 init_lvl_i,
  output logic                 sync_o
);
  logic [N_LANES-1:0] in_init;
  logic               sel_req;
  logic               req_q;
  logic               hold;
  logic               req_eff;

  initial begin
    if (N_LANES < 2)     $error("N_LANES must be at least 2");
    if (HOLD_CYCLES < 1) $error("HOLD_CYCLES must be at least 1");
  end

  sreq_lane_flags #(.N_LANES(N_LANES)) u_flags (
    .lane_state_i (lane_state_i),
    .in_init_o    (in_init)
  );

  sreq_select #(.N_LANES(N_LANES)) u_select (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .in_init_i (in_init),
    .sel_i     (sel_i),
    .req_o     (sel_req)
  );

  sreq_hold #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hold_o (hold)
  );

  // registered request removes glitches from simultaneous lane changes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= sel_req;
  end

  // init level and polarity are static config, so mixing after the flop is safe
  assign req_eff = hold ? init_lvl_i : req_q;
  assign sync_o  = pol_i ? req_eff : ~req_eff;

  p_track_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold && $past(rst_ni) && $stable(pol_i)) |->
      (sync_o == (pol_i ? $past(sel_req) : !$past(sel_req))));
  p_init_ignored_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold && $past(!hold) && $stable(pol_i) && $stable(req_q)) |-> $stable(sync_o));
endmodule

// File: tb/sync_req_gen_bench.sv
`timescale 1ns/1ps
module sync_req_gen_bench;
  localparam int N  = 4;
  localparam int HC = 2;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [2*N-1:0] lane_state = '0;
  logic [2:0]     sel = '0;
  logic           pol = 1'b0;
  logic           init_lvl = 1'b0;
  logic           sync_pin;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  sync_req_gen #(.N_LANES(N), .HOLD_CYCLES(HC)) u_sync_req_gen (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .lane_state_i (lane_state),
    .sel_i        (sel),
    .pol_i        (pol),
    .init_lvl_i   (init_lvl),
    .sync_o       (sync_pin)
  );

  function automatic logic exp_req(int s, int m);
    int cnt = 0;
    logic l0, l1;
    for (int i = 0; i < N; i++) if (((s >> (2*i)) & 3) == 0) cnt++;
    l0 = ((s & 3) == 0);
    l1 = (((s >> 2) & 3) == 0);
    case (m)
      1:       return cnt == N;
      2:       return l0;
      3:       return l1;
      default: return cnt != 0;
    endcase
  endfunction

  function automatic logic to_pin(logic r, logic p);
    return p ? r : ~r;
  endfunction

  task automatic check(logic got, logic exp, string req);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: sync_o=%b expected %b (sel=%0d pol=%b lanes=%h)",
               req, got, exp, sel, pol, lane_state);
    end
  endtask

  // reset pass: hold window R1, release, then init toggle R7
  task automatic reset_pass(logic lvl, logic p);
    @(negedge clk);
    rst_n = 1'b0; init_lvl = lvl; pol = p; sel = 3'b000;
    lane_state = lvl ? 8'hFF : 8'h00;  // lane-derived request opposes lvl
    #1;
    check(sync_pin, to_pin(lvl, p), "R1 in reset");
    @(negedge clk); rst_n = 1'b1;
    for (int k = 0; k < HC; k++) begin
      check(sync_pin, to_pin(lvl, p), "R1 hold window");
      @(negedge clk);
    end
    check(sync_pin, to_pin(!lvl, p), "R8 after release");
    init_lvl = !lvl;
    @(negedge clk);
    check(sync_pin, to_pin(!lvl, p), "R7 init change ignored");
    init_lvl = lvl;
    @(negedge clk);
    check(sync_pin, to_pin(!lvl, p), "R7 init change back");
  endtask

  initial begin
    for (int l = 0; l < 2; l++)
      for (int p = 0; p < 2; p++)
        reset_pass(1'(l), 1'(p));

    // exhaustive sweep: R2..R6, R9
    for (int m = 0; m < 8; m++)
      for (int p = 0; p < 2; p++)
        for (int s = 0; s < 256; s++) begin
          @(negedge clk);
          sel = 3'(m); pol = 1'(p); lane_state = 8'(s);
          @(negedge clk);
          check(sync_pin, to_pin(exp_req(s, m), 1'(p)),
                m >= 4 ? "R6 spare sel" : (m == 1 ? "R4 all" :
                (m >= 2 ? "R5 single lane" : "R3/R9 any")));
        end

    // R8: one-cycle latency, the output before the edge still shows the old value
    @(negedge clk);
    sel = 3'b010; pol = 1'b1; lane_state = 8'h01;
    @(negedge clk);
    check(sync_pin, 1'b0, "R8 settled");
    lane_state = 8'h00;
    #1;
    check(sync_pin, 1'b0, "R8 no combinational path");
    @(negedge clk);
    check(sync_pin, 1'b1, "R8 after edge");
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (50000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: expired, expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule